// File: doc/BRIEF.md
# TMDS Character Decoder with Control Demultiplexer

This block sits after symbol alignment in a digital display receiver. On every pixel clock it takes one 10-bit TMDS character from each of three colour channels. Channel 0 carries blue, channel 1 carries green and channel 2 carries red. The block works out whether each character is one of the four control characters or a data character.

When channel 0 holds a data character, the block decodes all three channels to 8-bit colour values and raises the data-enable output. When channel 0 holds a control character, the block is in blanking. It then updates the horizontal and vertical sync outputs from channel 0 and the three general control outputs from channels 1 and 2. The pixel output reads zero during blanking.

Every output is registered, so a result appears one clock after its characters. The sync and control outputs keep their last blanking values through active video.

Top module: `tmds_char_decoder`

## Requirements
- R1: While `rstN` is low, every output is zero, whatever characters are applied.
- R2: A data character is decoded as follows. If bit 9 is set, bits 7:0 are inverted first. The result is then un-chained: output bit 0 is taken as is, and output bit i is the XOR of bits i and i-1 when bit 8 is 1, or their XNOR when bit 8 is 0. The red, green and blue values come from channels 2, 1 and 0 and drive `pixelRgb[23:16]`, `[15:8]` and `[7:0]` one clock after the characters.
- R3: `dataEn` is high one clock after channel 0 holds a data character. It is low one clock after channel 0 holds a control character.
- R4: `pixelRgb` is all zeros whenever `dataEn` is low.
- R5: The control characters 0x354, 0x0AB, 0x154 and 0x2AB carry the 2-bit codes 00, 01, 10 and 11. In blanking, code bit 0 on channel 0 goes to `hsyncOut` and code bit 1 goes to `vsyncOut`, one clock later.
- R6: In blanking, channel 1 code bit 0 goes to `ctlOut[0]` (control 1), and channel 1 code bit 1 has no effect. Channel 2 code bit 0 goes to `ctlOut[1]` (control 2) and code bit 1 goes to `ctlOut[2]` (control 3).
- R7: While `dataEn` is high, `hsyncOut`, `vsyncOut` and `ctlOut` hold the values they had at the end of blanking.
- R8: In blanking, a data character on channel 1 or channel 2 leaves that channel's control outputs unchanged.
- R9: A 10-bit value that is not one of the four control characters is decoded as data. For example, 0x355 on channel 0 raises `dataEn` and yields blue 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blueChar | input | 10 | Channel 0 character |
| greenChar | input | 10 | Channel 1 character |
| redChar | input | 10 | Channel 2 character |
| pixelRgb | output | 24 | Decoded pixel: red 23:16, green 15:8, blue 7:0 |
| dataEn | output | 1 | High during active video |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| ctlOut | output | 3 | General controls 1 to 3 (bit 0 = control 1) |

## Verification
Data characters are built in the bench from chosen bytes, using all four combinations of the bit-8 chaining choice and the bit-9 inversion choice. This separates the XOR and XNOR paths and the inverted and plain paths. Each byte is checked on its own lane, so a channel swap also shows up.

Blanking runs walk all four control codes on channel 0. They give the two bits of each code different values on channels 1 and 2, which exposes bit swaps and a leak of channel 1's upper bit. Mixed runs cover the following cases:
- data characters on channels 1 and 2 during blanking;
- long active stretches after blanking, to show that the sync and control outputs hold;
- a near-miss of a control character on channel 0.

// File: rtl/tmdsdec_pkg.sv
package tmdsdec_pkg;
  localparam int CharW = 10;
  localparam int DataW = 8;
  localparam int NumCh = 3;
  localparam int CodeW = 2;
  localparam int PixW  = DataW * NumCh;

  typedef logic [CharW-1:0] char_t;
  typedef logic [DataW-1:0] data_t;
  typedef logic [CodeW-1:0] code_t;

  localparam char_t CtlChar00 = 10'h354;
  localparam char_t CtlChar01 = 10'h0AB;
  localparam char_t CtlChar10 = 10'h154;
  localparam char_t CtlChar11 = 10'h2AB;

  // Strobes from the control side to the datapath registers.
  typedef struct packed {
    logic loadPixel;  // active video: capture decoded colours
    logic loadSync;   // blanking: capture sync pair from channel 0
    logic loadCtlLo;  // blanking and channel 1 carries a control char
    logic loadCtlHi;  // blanking and channel 2 carries a control char
  } strobe_t;

  function automatic logic isCtlChar(char_t c);
    return (c == CtlChar00) || (c == CtlChar01) ||
           (c == CtlChar10) || (c == CtlChar11);
  endfunction

  function automatic code_t ctlCode(char_t c);
    code_t v;
    case (c)
      CtlChar01: v = 2'b01;
      CtlChar10: v = 2'b10;
      CtlChar11: v = 2'b11;
      default:   v = 2'b00;
    endcase
    return v;
  endfunction

  function automatic data_t decodeData(char_t c);
    data_t m;
    data_t d;
    m = c[CharW-1] ? ~c[DataW-1:0] : c[DataW-1:0];
    d[0] = m[0];
    for (int i = 1; i < DataW; i++) begin
      d[i] = c[DataW] ? (m[i] ^ m[i-1]) : ~(m[i] ^ m[i-1]);
    end
    return d;
  endfunction
endpackage

// File: rtl/tmdsdec_ctrl.sv
module tmdsdec_ctrl
  import tmdsdec_pkg::*;
(
  input  logic [NumCh-1:0][CharW-1:0] chars,
  output logic [NumCh-1:0]            isCtl,
  output strobe_t                     strobes
);
  for (genvar g = 0; g < NumCh; g++) begin : g_classify
    assign isCtl[g] = isCtlChar(chars[g]);
  end

  // Channel 0 alone decides between active video and blanking.
  always_comb begin
    strobes.loadPixel = !isCtl[0];
    strobes.loadSync  = isCtl[0];
    strobes.loadCtlLo = isCtl[0] && isCtl[1];
    strobes.loadCtlHi = isCtl[0] && isCtl[2];
  end
endmodule

// File: rtl/tmdsdec_datapath.sv
module tmdsdec_datapath
  import tmdsdec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NumCh-1:0][CharW-1:0] chars,
  input  logic [NumCh-1:0]            isCtl,
  input  strobe_t                     strobes,
  output logic [PixW-1:0]             pixelRgb,
  output logic                        dataEn,
  output logic                        hsyncOut,
  output logic                        vsyncOut,
  output logic [2:0]                  ctlOut
);
  logic [PixW-1:0]        pixNext;
  logic [NumCh-1:0][CodeW-1:0] codes;

  for (genvar g = 0; g < NumCh; g++) begin : g_lane
    assign pixNext[g*DataW +: DataW] = decodeData(chars[g]);
    assign codes[g] = ctlCode(chars[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixelRgb <= '0;
      dataEn   <= 1'b0;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      ctlOut   <= '0;
    end else begin
      dataEn   <= strobes.loadPixel;
      pixelRgb <= strobes.loadPixel ? pixNext : '0;
      if (strobes.loadSync) begin
        hsyncOut <= codes[0][0];
        vsyncOut <= codes[0][1];
      end
      if (strobes.loadCtlLo) ctlOut[0]   <= codes[1][0];
      if (strobes.loadCtlHi) ctlOut[2:1] <= codes[2];
    end
  end

  a_r4_pixel_blank: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> (pixelRgb == '0));

  a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> $stable({hsyncOut, vsyncOut, ctlOut}));

  a_r8_ctl1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (isCtl[0] && !isCtl[1]) |=> $stable(ctlOut[0]));

  a_r8_ctl23_hold: assert property (@(posedge clk) disable iff (!rstN)
    (isCtl[0] && !isCtl[2]) |=> $stable(ctlOut[2:1]));
endmodule

// File: rtl/tmds_char_decoder.sv
module tmds_char_decoder
  import tmdsdec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CharW-1:0] blueChar,
  input  logic [CharW-1:0] greenChar,
  input  logic [CharW-1:0] redChar,
  output logic [PixW-1:0]  pixelRgb,
  output logic             dataEn,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic [2:0]       ctlOut
);
  logic [NumCh-1:0][CharW-1:0] chars;
  logic [NumCh-1:0]            isCtl;
  strobe_t                     strobes;

  assign chars = {redChar, greenChar, blueChar};

  tmdsdec_ctrl u_ctrl (
    .chars   (chars),
    .isCtl   (isCtl),
    .strobes (strobes)
  );

  tmdsdec_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .chars    (chars),
    .isCtl    (isCtl),
    .strobes  (strobes),
    .pixelRgb (pixelRgb),
    .dataEn   (dataEn),
    .hsyncOut (hsyncOut),
    .vsyncOut (vsyncOut),
    .ctlOut   (ctlOut)
  );

  a_r3_de_rise: assert property (@(posedge clk) disable iff (!rstN)
    !isCtlChar(blueChar) |=> dataEn);

  a_r3_de_fall: assert property (@(posedge clk) disable iff (!rstN)
    isCtlChar(blueChar) |=> !dataEn);

  a_r5_both_sync: assert property (@(posedge clk) disable iff (!rstN)
    (blueChar == CtlChar11) |=> (hsyncOut && vsyncOut));

  a_r5_no_sync: assert property (@(posedge clk) disable iff (!rstN)
    (blueChar == CtlChar00) |=> (!hsyncOut && !vsyncOut));
endmodule

// File: tb/tmds_char_decoder_bench.sv
module tmds_char_decoder_bench;
  typedef struct {
    logic [23:0] pix;
    logic        de;
    logic        hs;
    logic        vs;
    logic [2:0]  ctl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  blueChar, greenChar, redChar;
  logic [23:0] pixelRgb;
  logic        dataEn, hsyncOut, vsyncOut;
  logic [2:0]  ctlOut;

  int checks = 0;
  int failures = 0;
  exp_t expq[$];
  logic mHs = 1'b0, mVs = 1'b0;
  logic [2:0] mCtl = 3'b000;

  always #2 clk = ~clk;

  tmds_char_decoder u_tmds_char_decoder (
    .clk(clk), .rstN(rstN), .blueChar(blueChar), .greenChar(greenChar),
    .redChar(redChar), .pixelRgb(pixelRgb), .dataEn(dataEn),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .ctlOut(ctlOut));

  function automatic int codeOf(logic [9:0] c);
    case (c)
      10'h354: return 0;
      10'h0AB: return 1;
      10'h154: return 2;
      10'h2AB: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [9:0] encode(logic [7:0] d, bit useXor, bit inv);
    logic [7:0] q;
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = useXor ? (q[i-1] ^ d[i]) : ~(q[i-1] ^ d[i]);
    return {inv, useXor, inv ? ~q : q};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Byte pick that never lands on a control character.
  task automatic safeChar(inout logic [7:0] d, input bit x, input bit v, output logic [9:0] c);
    c = encode(d, x, v);
    while (codeOf(c) >= 0) begin
      d = d ^ 8'h01;
      c = encode(d, x, v);
    end
  endtask

  task automatic sendPixel(logic [7:0] r, logic [7:0] g, logic [7:0] b, int variant, string tag);
    exp_t e;
    logic [9:0] cr, cg, cb;
    logic [7:0] rr = r, gg = g, bb = b;
    safeChar(rr, variant[0], variant[1], cr);
    safeChar(gg, variant[1], variant[0], cg);
    safeChar(bb, !variant[0], variant[1], cb);
    @(negedge clk);
    redChar = cr; greenChar = cg; blueChar = cb;
    e.pix = {rr, gg, bb}; e.de = 1'b1; e.hs = mHs; e.vs = mVs; e.ctl = mCtl; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic sendBlank(logic [1:0] hv, logic [9:0] c1, logic [9:0] c2, string tag);
    exp_t e;
    int k1, k2;
    k1 = codeOf(c1);
    k2 = codeOf(c2);
    @(negedge clk);
    blueChar = (hv == 2'b00) ? 10'h354 : (hv == 2'b01) ? 10'h0AB :
               (hv == 2'b10) ? 10'h154 : 10'h2AB;
    greenChar = c1; redChar = c2;
    mHs = hv[0]; mVs = hv[1];
    if (k1 >= 0) mCtl[0] = k1[0];
    if (k2 >= 0) mCtl[2:1] = k2[1:0];
    e.pix = '0; e.de = 1'b0; e.hs = mHs; e.vs = mVs; e.ctl = mCtl; e.tag = tag;
    expq.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      check(pixelRgb == e.pix, e.tag, "pixelRgb", 32'(pixelRgb), 32'(e.pix));
      check(dataEn == e.de, e.tag, "dataEn", 32'(dataEn), 32'(e.de));
      check({vsyncOut, hsyncOut} == {e.vs, e.hs}, e.tag, "vsync,hsync",
            32'({vsyncOut, hsyncOut}), 32'({e.vs, e.hs}));
      check(ctlOut == e.ctl, e.tag, "ctlOut", 32'(ctlOut), 32'(e.ctl));
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired, queue=%0d", expq.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: data characters applied during reset must not reach outputs.
    blueChar = 10'h2AB; greenChar = encode(8'hC3, 1, 0); redChar = 10'h2AB;
    repeat (3) @(posedge clk);
    @(negedge clk);
    blueChar = encode(8'h5A, 1, 1);
    @(posedge clk); #1;
    check({pixelRgb, dataEn, hsyncOut, vsyncOut, ctlOut} == '0, "R1", "reset outputs",
          32'({pixelRgb, dataEn}), 32'h0);
    @(negedge clk);
    blueChar = 10'h354; greenChar = 10'h354; redChar = 10'h354;
    rstN = 1'b1;

    // R5 R6: each code on channel 0, distinct bits on channels 1 and 2.
    sendBlank(2'b11, 10'h0AB, 10'h2AB, "R5 R6");
    sendBlank(2'b00, 10'h154, 10'h154, "R5 R6");   // ch1 bit1 ignored
    sendBlank(2'b01, 10'h2AB, 10'h0AB, "R5 R6");
    sendBlank(2'b10, 10'h354, 10'h354, "R5 R6");
    sendBlank(2'b01, 10'h0AB, 10'h154, "R6");

    // R2 R3 R7: decode across variants; sync/control hold.
    sendPixel(8'h00, 8'hFF, 8'hA5, 0, "R2 R3 R7");
    sendPixel(8'h3C, 8'h81, 8'h7E, 1, "R2 R7");
    sendPixel(8'hF0, 8'h0F, 8'h55, 2, "R2 R7");
    sendPixel(8'h12, 8'hED, 8'hC8, 3, "R2 R7");
    for (int i = 0; i < 16; i++)
      sendPixel(8'(i * 37 + 5), 8'(i * 91), 8'(255 - i * 13), i % 4, "R2 R7");

    // R3 R4: back to blanking, pixel zeroed.
    sendBlank(2'b11, 10'h354, 10'h2AB, "R3 R4");

    // R8: data characters on channels 1 and 2 during blanking.
    sendBlank(2'b00, encode(8'h66, 1, 0), encode(8'h99, 0, 1), "R8");
    sendBlank(2'b10, encode(8'h01, 0, 0), 10'h354, "R8");
    sendBlank(2'b01, 10'h0AB, encode(8'hEE, 1, 1), "R8");

    // R9: near-miss of a control character on channel 0 decodes as data.
    begin
      exp_t e;
      @(negedge clk);
      blueChar = 10'h355; greenChar = encode(8'h44, 1, 0); redChar = encode(8'h88, 0, 0);
      e.pix = {8'h88, 8'h44, 8'hFE}; e.de = 1'b1; e.hs = mHs; e.vs = mVs; e.ctl = mCtl;
      e.tag = "R9";
      expq.push_back(e);
    end
    sendBlank(2'b00, 10'h354, 10'h354, "R4 R5");

    while (expq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule